// File: doc/BRIEF.md
# Audio Serial Clock Divider Chain

This block turns a source clock, presented as a one-cycle enable on the system clock, into two clock-enable streams for an audio serial port. The first stream is a master clock. The second is a bit clock. The master clock comes from a cascade of a fixed halving stage, a prescaler of 1 or 8, and a modulus divider of 1 to 256. The bit clock comes from a further divider of 1 to 16. That last divider is fed by the master clock, by an external master-clock pin, or directly by the source when the upper stages are bypassed.

There are two independent divider sets, one for transmit and one for receive. In synchronous mode the receive outputs follow the transmit set. Software picks every ratio. It writes them through a single configuration word port, which accepts writes only while the block is idle. Each divider is a down-counter that starts at its reload value when the block is enabled, so the first output pulse comes exactly one full period after the start.

Top module: `clkdiv_chain`

## Requirements
- R1: With no bypass and no pin input, `sck_tick` pulses once every 2·P·M·F source ticks. The first pulse appears on the 2·P·M·F-th source tick after enable is first sampled high.
- R2: `hck_tick` pulses once every 2·P·M source ticks, and the final divider F has no effect on it. The first pulse appears on the 2·P·M-th source tick.
- R3: Bit 12 of the configuration word selects the prescaler P: 0 gives P = 1 and 1 gives P = 8.
- R4: Bits [7:0] hold M−1 (M from 1 to 256) and bits [11:8] hold F−1 (F from 1 to 16). The extremes give ratios of 2 and 65536.
- R5: `sck_lvl` is high for ceil(F/2) and low for floor(F/2) of every F ticks that feed the final divider. It changes only after such a tick.
- R6: With bit 13 (bypass) set, `hck_tick` follows every source tick, and `sck_tick` divides the source by F alone.
- R7: With bit 14 (pin input) set, the final divider counts pin ticks instead of the master clock, and `hck_oe` is low. Otherwise `hck_oe` is high.
- R8: Bit 15 of a transmit-side write (`cfg_side` = 0) selects synchronous mode, in which all receive outputs follow the transmit set.
- R9: A configuration write is ignored while `enable` is high or in the cycle after it falls. The stored ratios stay unchanged.
- R10: During reset and while disabled, all tick and level outputs are low.
- R11: Dividers advance only on cycles where `src_tick` is high, so a source at half rate doubles every period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run control; dividers start one cycle after it is sampled high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_side | input | 1 | Target set of the write: 0 transmit, 1 receive |
| cfg_wdata | input | 16 | Configuration word (fields given in R3, R4 and R6 to R8) |
| src_tick | input | 1 | Source clock enable |
| tx_pin_tick | input | 1 | Transmit master-clock pin, as a clock enable |
| rx_pin_tick | input | 1 | Receive master-clock pin, as a clock enable |
| tx_hck_tick | output | 1 | Transmit master-clock enable |
| tx_hck_oe | output | 1 | Transmit master-clock pin drive enable |
| tx_sck_tick | output | 1 | Transmit bit-clock enable |
| tx_sck_lvl | output | 1 | Transmit bit-clock level |
| rx_hck_tick | output | 1 | Receive master-clock enable |
| rx_hck_oe | output | 1 | Receive master-clock pin drive enable |
| rx_sck_tick | output | 1 | Receive bit-clock enable |
| rx_sck_lvl | output | 1 | Receive bit-clock level |

## Verification
The bench builds the block with the default field widths: an 8-bit modulus, a 4-bit final divider and a prescaler of 8. With these defaults the largest ratio, 65536 source ticks per bit-clock period, can be measured within a single run, and the smallest ratio of 2 can be measured as well. Because the widths are small, the random cases can sweep prescaler, modulus and odd or even final ratios on both sides. They still have room for directed runs of bypass, pin input, a half-rate source and synchronous mode.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int MOD_W      = 8;
  localparam int FIN_W      = 4;
  localparam int PRE_RATIO  = 8;
  localparam int PRE_W      = $clog2(PRE_RATIO);
  localparam int SIDES      = 2;

  // field order matters: it is the configuration word layout, LSB last
  typedef struct packed {
    logic             pin_in;
    logic             bypass;
    logic             pre8;
    logic [FIN_W-1:0] fin_m1;
    logic [MOD_W-1:0] mod_m1;
  } side_cfg_t;

  localparam int SIDE_CFG_W = $bits(side_cfg_t);
  localparam int CFG_W      = SIDE_CFG_W + 1;
endpackage

// File: rtl/clkdiv_stage.sv
module clkdiv_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         in_tick,
  input  logic [W-1:0] ratio_m1,
  output logic         out_tick
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run) begin
      cnt_d = ratio_m1;
    end else if (in_tick) begin
      cnt_d = (cnt_q == '0) ? ratio_m1 : cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign out_tick = run & in_tick & (cnt_q == '0);
endmodule

// File: rtl/clkdiv_final.sv
module clkdiv_final #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         in_tick,
  input  logic [W-1:0] ratio_m1,
  output logic         out_tick,
  output logic         out_lvl
);
  logic [W-1:0] cnt_q, cnt_d;
  logic [W:0]   half;

  always_comb begin
    cnt_d = cnt_q;
    if (!run) begin
      cnt_d = ratio_m1;
    end else if (in_tick) begin
      cnt_d = (cnt_q == '0) ? ratio_m1 : cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // high while the count sits in the upper ceil(N/2) values
  assign half     = ({1'b0, ratio_m1} + (W+1)'(1)) >> 1;
  assign out_tick = run & in_tick & (cnt_q == '0);
  assign out_lvl  = run & ({1'b0, cnt_q} >= half);
endmodule

// File: rtl/clkdiv_side.sv
module clkdiv_side
  import clkdiv_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run,
  input  logic      src_tick,
  input  logic      pin_tick,
  input  side_cfg_t cfg,
  output logic      hck_tick,
  output logic      hck_oe,
  output logic      sck_tick,
  output logic      sck_lvl,
  output logic      sck_base
);
  logic             src_run;
  logic             half_t;
  logic             pre_t;
  logic             mod_t;
  logic [PRE_W-1:0] pre_m1;

  assign src_run = run & src_tick;
  assign pre_m1  = cfg.pre8 ? PRE_W'(PRE_RATIO - 1) : '0;

  clkdiv_stage #(.W(1)) u_half (
    .clk(clk), .rst_n(rst_n), .run(run), .in_tick(src_run),
    .ratio_m1(1'b1), .out_tick(half_t)
  );

  clkdiv_stage #(.W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .in_tick(half_t),
    .ratio_m1(pre_m1), .out_tick(pre_t)
  );

  clkdiv_stage #(.W(MOD_W)) u_mod (
    .clk(clk), .rst_n(rst_n), .run(run), .in_tick(pre_t),
    .ratio_m1(cfg.mod_m1), .out_tick(mod_t)
  );

  assign hck_tick = cfg.bypass ? src_run : mod_t;
  assign hck_oe   = !cfg.pin_in;
  assign sck_base = cfg.pin_in ? (run & pin_tick) : hck_tick;

  clkdiv_final #(.W(FIN_W)) u_fin (
    .clk(clk), .rst_n(rst_n), .run(run), .in_tick(sck_base),
    .ratio_m1(cfg.fin_m1), .out_tick(sck_tick), .out_lvl(sck_lvl)
  );
endmodule

// File: rtl/clkdiv_chain.sv
module clkdiv_chain
  import clkdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             cfg_we,
  input  logic             cfg_side,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             src_tick,
  input  logic             tx_pin_tick,
  input  logic             rx_pin_tick,
  output logic             tx_hck_tick,
  output logic             tx_hck_oe,
  output logic             tx_sck_tick,
  output logic             tx_sck_lvl,
  output logic             rx_hck_tick,
  output logic             rx_hck_oe,
  output logic             rx_sck_tick,
  output logic             rx_sck_lvl
);
  logic [1:0]       rst_pipe;
  logic             rst_n_s;
  logic             run_q, run_d;
  logic             sync_q, sync_d;
  logic             cfg_open;
  side_cfg_t        cfg_q [SIDES];
  side_cfg_t        cfg_d [SIDES];
  logic [SIDES-1:0] pin_t, hck_t, hck_oe_s, sck_t, sck_l, sck_base;

  // reset asserts at once, leaves two clock edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  always_comb begin
    cfg_open = !enable && !run_q;
    run_d    = enable;
    sync_d   = sync_q;
    for (int s = 0; s < SIDES; s++) begin
      cfg_d[s] = cfg_q[s];
      if (cfg_open && cfg_we && (int'(cfg_side) == s)) begin
        cfg_d[s] = side_cfg_t'(cfg_wdata[SIDE_CFG_W-1:0]);
      end
    end
    if (cfg_open && cfg_we && !cfg_side) sync_d = cfg_wdata[CFG_W-1];
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      run_q  <= 1'b0;
      sync_q <= 1'b0;
      for (int s = 0; s < SIDES; s++) cfg_q[s] <= '0;
    end else begin
      run_q  <= run_d;
      sync_q <= sync_d;
      for (int s = 0; s < SIDES; s++) cfg_q[s] <= cfg_d[s];
    end
  end

  assign pin_t = {rx_pin_tick, tx_pin_tick};

  for (genvar g = 0; g < SIDES; g++) begin : g_side
    clkdiv_side u_side (
      .clk(clk), .rst_n(rst_n_s), .run(run_q), .src_tick(src_tick),
      .pin_tick(pin_t[g]), .cfg(cfg_q[g]),
      .hck_tick(hck_t[g]), .hck_oe(hck_oe_s[g]), .sck_tick(sck_t[g]),
      .sck_lvl(sck_l[g]), .sck_base(sck_base[g])
    );
  end

  assign tx_hck_tick = hck_t[0];
  assign tx_hck_oe   = hck_oe_s[0];
  assign tx_sck_tick = sck_t[0];
  assign tx_sck_lvl  = sck_l[0];
  assign rx_hck_tick = sync_q ? hck_t[0]    : hck_t[1];
  assign rx_hck_oe   = sync_q ? hck_oe_s[0] : hck_oe_s[1];
  assign rx_sck_tick = sync_q ? sck_t[0]    : sck_t[1];
  assign rx_sck_lvl  = sync_q ? sck_l[0]    : sck_l[1];
endmodule

// File: rtl/clkdiv_chain_sva.sv
module clkdiv_chain_sva
  import clkdiv_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             sync,
  input side_cfg_t        tx_cfg,
  input side_cfg_t        rx_cfg,
  input logic [SIDES-1:0] base,
  input logic [SIDES-1:0] lvl,
  input logic             tx_hck_tick,
  input logic             tx_sck_tick,
  input logic             tx_sck_lvl,
  input logic             rx_hck_tick,
  input logic             rx_sck_tick,
  input logic             rx_sck_lvl
);
  assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !(tx_hck_tick || tx_sck_tick || tx_sck_lvl ||
               rx_hck_tick || rx_sck_tick || rx_sck_lvl));

  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> ($stable(tx_cfg) && $stable(rx_cfg) && $stable(sync)));

  assert_sck_on_hck_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sck_tick && !tx_cfg.pin_in && !tx_cfg.bypass) |-> tx_hck_tick);

  assert_tx_lvl_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(base[0])) |-> $stable(lvl[0]));

  assert_rx_lvl_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(base[1])) |-> $stable(lvl[1]));
endmodule

bind clkdiv_chain clkdiv_chain_sva u_sva (
  .clk(clk), .rst_n(rst_n), .run(run_q), .sync(sync_q),
  .tx_cfg(cfg_q[0]), .rx_cfg(cfg_q[1]), .base(sck_base), .lvl(sck_l),
  .tx_hck_tick(tx_hck_tick), .tx_sck_tick(tx_sck_tick), .tx_sck_lvl(tx_sck_lvl),
  .rx_hck_tick(rx_hck_tick), .rx_sck_tick(rx_sck_tick), .rx_sck_lvl(rx_sck_lvl)
);

// File: tb/clkdiv_chain_tb.sv
`timescale 1ns/1ps
module clkdiv_chain_tb;
  import clkdiv_pkg::*;

  logic clk = 1'b0;
  logic rst_n, enable, cfg_we, cfg_side, src_tick;
  logic [CFG_W-1:0] cfg_wdata;
  logic tx_pin_tick, rx_pin_tick;
  logic tx_hck_tick, tx_hck_oe, tx_sck_tick, tx_sck_lvl;
  logic rx_hck_tick, rx_hck_oe, rx_sck_tick, rx_sck_lvl;

  int n_chk = 0;
  int n_fail = 0;
  bit src_half = 1'b0;
  int pcnt = 0;

  always #4 clk = ~clk;

  clkdiv_chain u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we),
    .cfg_side(cfg_side), .cfg_wdata(cfg_wdata), .src_tick(src_tick),
    .tx_pin_tick(tx_pin_tick), .rx_pin_tick(rx_pin_tick),
    .tx_hck_tick(tx_hck_tick), .tx_hck_oe(tx_hck_oe),
    .tx_sck_tick(tx_sck_tick), .tx_sck_lvl(tx_sck_lvl),
    .rx_hck_tick(rx_hck_tick), .rx_hck_oe(rx_hck_oe),
    .rx_sck_tick(rx_sck_tick), .rx_sck_lvl(rx_sck_lvl)
  );

  always @(negedge clk) begin
    src_tick <= src_half ? ~src_tick : 1'b1;
    pcnt     <= (pcnt == 2) ? 0 : pcnt + 1;
  end
  assign tx_pin_tick = (pcnt == 0);
  assign rx_pin_tick = (pcnt == 0);

  function automatic int hck_ratio(bit p8, int m);
    return 2 * (p8 ? PRE_RATIO : 1) * m;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(bit side, bit p8, int m, int f, bit byp, bit pin, bit sync);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_side  = side;
    cfg_wdata = {sync, pin, byp, p8, FIN_W'(f - 1), MOD_W'(m - 1)};
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic idle_quiet(string req);
    int any;
    @(negedge clk);
    any = int'(tx_hck_tick) + int'(tx_sck_tick) + int'(tx_sck_lvl) +
          int'(rx_hck_tick) + int'(rx_sck_tick) + int'(rx_sck_lvl);
    chk(any == 0, req, "outputs active while idle", any, 0);
  endtask

  task automatic measure(int side, int exp_h, int exp_s, int hi_exp,
                         bit chk_first, int window, string tag);
    int h1 = 0, h2 = 0, s1 = 0, s2 = 0, hi = 0;
    logic ht, st, sl;
    @(negedge clk);
    enable = 1'b1;
    @(posedge clk);
    for (int k = 1; k <= window; k++) begin
      @(negedge clk);
      ht = (side == 0) ? tx_hck_tick : rx_hck_tick;
      st = (side == 0) ? tx_sck_tick : rx_sck_tick;
      sl = (side == 0) ? tx_sck_lvl  : rx_sck_lvl;
      if (ht) begin if (h1 == 0) h1 = k; else if (h2 == 0) h2 = k; end
      if (st) begin if (s1 == 0) s1 = k; else if (s2 == 0) s2 = k; end
      if (sl && k <= exp_s) hi++;
    end
    enable = 1'b0;
    @(posedge clk);
    @(posedge clk);
    if (exp_h > 0) begin
      if (chk_first) chk(h1 == exp_h, tag, "first hck tick", h1, exp_h);
      chk(h2 - h1 == exp_h, tag, "hck period", h2 - h1, exp_h);
    end
    if (chk_first) chk(s1 == exp_s, tag, "first sck tick", s1, exp_s);
    if (s2 != 0 || !chk_first) chk(s2 - s1 == exp_s, tag, "sck period", s2 - s1, exp_s);
    if (hi_exp >= 0) chk(hi == hi_exp, tag, "sck high cycles", hi, hi_exp);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20117));
    rst_n = 1'b0; enable = 1'b0; cfg_we = 1'b0; cfg_side = 1'b0;
    cfg_wdata = '0; src_tick = 1'b1;
    idle_quiet("R10");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    idle_quiet("R10");

    // smallest ratio (R4, R1, R2)
    cfg_write(0, 0, 1, 1, 0, 0, 0);
    chk(tx_hck_oe == 1'b1, "R7", "hck_oe with internal chain", tx_hck_oe, 1);
    measure(0, 2, 2, 2, 1, 8, "R1 R2 R4 min");
    idle_quiet("R10");
    // odd final ratio: duty (R5)
    cfg_write(0, 0, 3, 5, 0, 0, 0);
    measure(0, 6, 30, 18, 1, 64, "R5 odd final");
    // prescaler of 8 (R3)
    cfg_write(0, 1, 1, 2, 0, 0, 0);
    measure(0, 16, 32, 16, 1, 70, "R3 prescaler");
    // largest ratio (R4)
    cfg_write(0, 1, 256, 16, 0, 0, 0);
    measure(0, 4096, 65536, 32768, 1, 65536 + 4100, "R4 max");
    // bypass (R6)
    cfg_write(0, 0, 1, 7, 1, 0, 0);
    measure(0, 1, 7, 4, 1, 20, "R6 bypass");
    // master-clock pin as input (R7)
    cfg_write(0, 0, 2, 3, 0, 1, 0);
    @(negedge clk);
    chk(tx_hck_oe == 1'b0, "R7", "hck_oe with pin input", tx_hck_oe, 0);
    measure(0, 4, 9, -1, 0, 40, "R7 pin input");
    // half-rate source (R11)
    src_half = 1'b1;
    cfg_write(0, 0, 2, 2, 0, 0, 0);
    measure(0, 8, 16, -1, 0, 60, "R11 half source");
    src_half = 1'b0;
    repeat (2) @(negedge clk);
    // synchronous mode (R8)
    cfg_write(1, 0, 5, 1, 0, 0, 0);
    cfg_write(0, 0, 2, 3, 0, 0, 1);
    measure(1, 4, 12, 8, 1, 40, "R8 sync follows tx");
    cfg_write(0, 0, 2, 3, 0, 0, 0);
    measure(1, 10, 10, 10, 1, 40, "R8 rx own set");
    // write while running is dropped (R9)
    @(negedge clk);
    enable = 1'b1;
    repeat (5) @(negedge clk);
    cfg_write(1, 1, 9, 7, 0, 0, 0);
    @(negedge clk);
    enable = 1'b0;
    @(posedge clk);
    @(posedge clk);
    idle_quiet("R10");
    measure(1, 10, 10, 10, 1, 40, "R9 write ignored");
    // random mix (R1 R2 R3 R5)
    for (int i = 0; i < 6; i++) begin
      bit p8 = 1'($urandom_range(0, 1));
      int m  = $urandom_range(1, 24);
      int f  = $urandom_range(1, 6);
      int sd = $urandom_range(0, 1);
      int h  = hck_ratio(p8, m);
      cfg_write(1'(sd), p8, m, f, 0, 0, 0);
      measure(sd, h, h * f, ((f + 1) / 2) * h, 1, 2 * h * f + 4, "R1 R2 R3 R5 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule